// File: doc/BRIEF.md
# Network Bridge Command Decoder

This block takes 32-bit command words from an on-chip bus and turns them into the settings a UDP transmit/receive engine needs. The top four bits of each header word select the command: set up the transmit side (which also claims an exclusive transmit lock), set up the receive side, announce a data packet of a given byte length, or give the lock back. Both configuration commands run over four words. When one completes, the block sends a single typed acknowledgement word back to the bus address that the requester supplied.

The transmit lock belongs to one return address at a time. It is freed by an explicit release or when its timeout counter runs out. Data headers with an impossible length, and headers with an opcode the block does not know, are dropped and flagged with a one-cycle error pulse. Input words use a valid/ready handshake. `in_ready` drops only in the cycle in which an acknowledgement is being presented.

Top module: `netcmd_decoder`

## Requirements
- R1: While reset is held and just after it ends, `lock_held`, `ack_valid`, `pay_len_valid` and `err_pulse` are 0 and `in_ready` is 1.
- R2: A receive configuration has four words: a header with 0x3 in bits 31:28, the IP word, the port word, and the return address. It loads the `rx_*` outputs. In the cycle after the fourth word is accepted, `ack_valid` is 1, `ack_word` is 0x50000000 and `ack_dest` is the return address.
- R3: A transmit configuration has four words: a header with 0x0 in bits 31:28 and the timeout in bits 27:0, then IP, ports and return address. If the lock is free, it loads the `tx_*` outputs and sets `lock_held`. In the cycle after the fourth word, the block sends `ack_word` 0x58000000 (bit 27 set) to the return address.
- R4: In the port word, bits 31:16 are the destination port and bits 15:0 are the source port.
- R5: A transmit configuration from a different return address while the lock is held gets no acknowledgement and leaves the `tx_*` outputs unchanged. The holder may configure again, which reloads its timeout.
- R6: A data header has 0x1 in bits 31:28 and the byte length in bits 27:17. With a length from 1 to 1472, `pay_len` shows that length and `pay_len_valid` pulses for one cycle, in the cycle after acceptance.
- R7: A data header with length 0 or above 1472 raises `err_pulse` for one cycle and does not raise `pay_len_valid`.
- R8: A header with an opcode of 0x4 to 0xF (0x5 included) raises `err_pulse` for one cycle.
- R9: A single header word with 0x2 in bits 31:28 clears `lock_held` and raises no error.
- R10: A lock granted with timeout T stays held for T+1 cycles after the grant and then frees itself.
- R11: Idle gaps between the words of a configuration do not break it. `in_ready` is 0 in the cycle in which an acknowledgement is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command word valid |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Block accepts a word this cycle |
| ack_valid | output | 1 | Acknowledgement word present (one cycle) |
| ack_word | output | 32 | Acknowledgement header |
| ack_dest | output | 32 | Bus address the acknowledgement goes to |
| tx_ip | output | 32 | Transmit destination IP |
| tx_dst_port | output | 16 | Transmit destination port |
| tx_src_port | output | 16 | Transmit source port |
| tx_ret_addr | output | 32 | Return address of lock holder |
| tx_timeout | output | 28 | Transmit lock timeout |
| rx_ip | output | 32 | Receive IP |
| rx_dst_port | output | 16 | Receive destination port |
| rx_src_port | output | 16 | Receive source port |
| rx_ret_addr | output | 32 | Receive return address |
| pay_len | output | 11 | Last accepted payload length in bytes |
| pay_len_valid | output | 1 | New payload length (one cycle) |
| lock_held | output | 1 | Transmit lock is owned |
| err_pulse | output | 1 | Dropped header (one cycle) |

## Verification
The assertions assume that agents never start a new command in the middle of another one. Once the header of a configuration is accepted, the next three accepted words are taken as its body, whatever their top bits hold. The release and error properties therefore refer to words that arrive in the header phase. The stimulus always sends a configuration's four words back to back, with optional idle cycles between them. It interleaves only whole commands, so no payload word can be mistaken for a header.

// File: rtl/netcmd_pkg.sv
package netcmd_pkg;
   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_TX_CFG  = 4'h0,
      OP_DATA    = 4'h1,
      OP_RELEASE = 4'h2,
      OP_RX_CFG  = 4'h3,
      OP_ACK     = 4'h5
   } op_e;

   typedef enum logic [1:0] {
      PH_HDR,
      PH_IP,
      PH_PORT,
      PH_RET
   } phase_e;
endpackage

// File: rtl/netcmd_collector.sv
module netcmd_collector
   import netcmd_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int TIMEOUT_W = 28
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 acc,
   input  logic [DATA_W-1:0]    word,
   output logic                 hdr_phase,
   output logic                 cfg_done,
   output logic                 cfg_is_tx,
   output logic [TIMEOUT_W-1:0] cfg_timeout,
   output logic [DATA_W-1:0]    cfg_ip,
   output logic [DATA_W-1:0]    cfg_ports
);
   localparam int OP_LSB = DATA_W - OP_W;

   phase_e ph_q;
   op_e    op;

   assign op        = op_e'(word[DATA_W-1:OP_LSB]);
   assign hdr_phase = (ph_q == PH_HDR);
   assign cfg_done  = acc && (ph_q == PH_RET);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q        <= PH_HDR;
         cfg_is_tx   <= 1'b0;
         cfg_timeout <= '0;
         cfg_ip      <= '0;
         cfg_ports   <= '0;
      end else if (acc) begin
         unique case (ph_q)
            PH_HDR: begin
               if (op == OP_TX_CFG || op == OP_RX_CFG) begin
                  ph_q        <= PH_IP;
                  cfg_is_tx   <= (op == OP_TX_CFG);
                  cfg_timeout <= word[TIMEOUT_W-1:0];
               end
            end
            PH_IP: begin
               cfg_ip <= word;
               ph_q   <= PH_PORT;
            end
            PH_PORT: begin
               cfg_ports <= word;
               ph_q      <= PH_RET;
            end
            PH_RET: ph_q <= PH_HDR;
            default: ph_q <= PH_HDR;
         endcase
      end
   end
endmodule

// File: rtl/netcmd_lock.sv
module netcmd_lock #(
   parameter int TIMEOUT_W          = 28,
   parameter int ADDR_W             = 32,
   parameter bit REGRANT_SAME_OWNER = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req,
   input  logic [ADDR_W-1:0]    req_owner,
   input  logic [TIMEOUT_W-1:0] req_timeout,
   input  logic                 release_i,
   output logic                 granted,
   output logic                 held
);
   logic                 held_q;
   logic [ADDR_W-1:0]    owner_q;
   logic [TIMEOUT_W-1:0] timer_q;
   logic                 owner_ok;

   generate
      if (REGRANT_SAME_OWNER) begin : g_regrant
         assign owner_ok = (owner_q == req_owner);
      end else begin : g_strict
         assign owner_ok = 1'b0;
      end
   endgenerate

   assign granted = req && (!held_q || owner_ok);
   assign held    = held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q  <= 1'b0;
         owner_q <= '0;
         timer_q <= '0;
      end else if (granted) begin
         held_q  <= 1'b1;
         owner_q <= req_owner;
         timer_q <= req_timeout;
      end else if (release_i) begin
         held_q <= 1'b0;
      end else if (held_q) begin
         if (timer_q == '0) held_q <= 1'b0;
         else               timer_q <= timer_q - 1'b1;
      end
   end
endmodule

// File: rtl/netcmd_len_check.sv
module netcmd_len_check #(
   parameter int LEN_W   = 11,
   parameter int MAX_LEN = 1472
) (
   input  logic [LEN_W-1:0] len_field,
   output logic             len_ok
);
   localparam logic [LEN_W-1:0] MAX_V = LEN_W'(MAX_LEN);

   assign len_ok = (len_field != '0) && (len_field <= MAX_V);
endmodule

// File: rtl/netcmd_decoder.sv
module netcmd_decoder
   import netcmd_pkg::*;
#(
   parameter int DATA_W             = 32,
   parameter int TIMEOUT_W          = 28,
   parameter int LEN_W              = 11,
   parameter int LEN_LSB            = 17,
   parameter int MAX_LEN            = 1472,
   parameter bit REGRANT_SAME_OWNER = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [DATA_W-1:0]      in_data,
   output logic                   in_ready,
   output logic                   ack_valid,
   output logic [DATA_W-1:0]      ack_word,
   output logic [DATA_W-1:0]      ack_dest,
   output logic [DATA_W-1:0]      tx_ip,
   output logic [DATA_W/2-1:0]    tx_dst_port,
   output logic [DATA_W/2-1:0]    tx_src_port,
   output logic [DATA_W-1:0]      tx_ret_addr,
   output logic [TIMEOUT_W-1:0]   tx_timeout,
   output logic [DATA_W-1:0]      rx_ip,
   output logic [DATA_W/2-1:0]    rx_dst_port,
   output logic [DATA_W/2-1:0]    rx_src_port,
   output logic [DATA_W-1:0]      rx_ret_addr,
   output logic [LEN_W-1:0]       pay_len,
   output logic                   pay_len_valid,
   output logic                   lock_held,
   output logic                   err_pulse
);
   localparam int OP_LSB = DATA_W - OP_W;
   localparam int PORT_W = DATA_W / 2;

   generate
      if (DATA_W % 2 != 0) begin : g_bad_width
         $error("DATA_W must be even");
      end
      if (TIMEOUT_W > OP_LSB) begin : g_bad_timeout
         $error("timeout field overlaps opcode");
      end
      if (LEN_LSB + LEN_W > OP_LSB) begin : g_bad_len
         $error("length field overlaps opcode");
      end
      if (MAX_LEN < 1 || MAX_LEN >= (1 << LEN_W)) begin : g_bad_max
         $error("MAX_LEN does not fit the length field");
      end
   endgenerate

   logic                 acc, hdr_phase, hdr_acc;
   logic                 cfg_done, cfg_is_tx, granted, release_hdr, len_ok;
   logic [TIMEOUT_W-1:0] cfg_timeout;
   logic [DATA_W-1:0]    cfg_ip, cfg_ports;
   logic [LEN_W-1:0]     len_field;
   op_e                  op;

   assign in_ready    = !ack_valid;
   assign acc         = in_valid && in_ready;
   assign hdr_acc     = acc && hdr_phase;
   assign op          = op_e'(in_data[DATA_W-1:OP_LSB]);
   assign len_field   = in_data[LEN_LSB +: LEN_W];
   assign release_hdr = hdr_acc && (op == OP_RELEASE);

   netcmd_collector #(.DATA_W(DATA_W), .TIMEOUT_W(TIMEOUT_W)) u_coll (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc         (acc),
      .word        (in_data),
      .hdr_phase   (hdr_phase),
      .cfg_done    (cfg_done),
      .cfg_is_tx   (cfg_is_tx),
      .cfg_timeout (cfg_timeout),
      .cfg_ip      (cfg_ip),
      .cfg_ports   (cfg_ports)
   );

   netcmd_lock #(
      .TIMEOUT_W          (TIMEOUT_W),
      .ADDR_W             (DATA_W),
      .REGRANT_SAME_OWNER (REGRANT_SAME_OWNER)
   ) u_lock (
      .clk         (clk),
      .rst_n       (rst_n),
      .req         (cfg_done && cfg_is_tx),
      .req_owner   (in_data),
      .req_timeout (cfg_timeout),
      .release_i   (release_hdr),
      .granted     (granted),
      .held        (lock_held)
   );

   netcmd_len_check #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_len (
      .len_field (len_field),
      .len_ok    (len_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_valid     <= 1'b0;
         ack_word      <= '0;
         ack_dest      <= '0;
         tx_ip         <= '0;
         tx_dst_port   <= '0;
         tx_src_port   <= '0;
         tx_ret_addr   <= '0;
         tx_timeout    <= '0;
         rx_ip         <= '0;
         rx_dst_port   <= '0;
         rx_src_port   <= '0;
         rx_ret_addr   <= '0;
         pay_len       <= '0;
         pay_len_valid <= 1'b0;
         err_pulse     <= 1'b0;
      end else begin
         ack_valid     <= 1'b0;
         pay_len_valid <= 1'b0;
         err_pulse     <= 1'b0;
         if (cfg_done && !cfg_is_tx) begin
            rx_ip       <= cfg_ip;
            rx_dst_port <= cfg_ports[DATA_W-1:PORT_W];
            rx_src_port <= cfg_ports[PORT_W-1:0];
            rx_ret_addr <= in_data;
            ack_valid   <= 1'b1;
            ack_word    <= {OP_ACK, 1'b0, {(OP_LSB-1){1'b0}}};
            ack_dest    <= in_data;
         end
         if (granted) begin
            tx_ip       <= cfg_ip;
            tx_dst_port <= cfg_ports[DATA_W-1:PORT_W];
            tx_src_port <= cfg_ports[PORT_W-1:0];
            tx_ret_addr <= in_data;
            tx_timeout  <= cfg_timeout;
            ack_valid   <= 1'b1;
            ack_word    <= {OP_ACK, 1'b1, {(OP_LSB-1){1'b0}}};
            ack_dest    <= in_data;
         end
         if (hdr_acc) begin
            case (op)
               OP_DATA: begin
                  if (len_ok) begin
                     pay_len       <= len_field;
                     pay_len_valid <= 1'b1;
                  end else begin
                     err_pulse <= 1'b1;
                  end
               end
               OP_TX_CFG, OP_RX_CFG, OP_RELEASE: ;
               default: err_pulse <= 1'b1;
            endcase
         end
      end
   end
endmodule

// File: rtl/netcmd_decoder_chk.sv
module netcmd_decoder_chk #(
   parameter int DATA_W  = 32,
   parameter int LEN_W   = 11,
   parameter int MAX_LEN = 1472
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [DATA_W-1:0] in_data,
   input logic              hdr_phase,
   input logic              ack_valid,
   input logic [DATA_W-1:0] ack_word,
   input logic [LEN_W-1:0]  pay_len,
   input logic              pay_len_valid,
   input logic              err_pulse,
   input logic              lock_held
);
   AST_ACK_FOLLOWS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> $past(in_valid && in_ready)); // R2
   AST_ACK_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> (ack_word[DATA_W-1:DATA_W-4] == 4'h5 && ack_word[DATA_W-6:0] == '0)); // R2
   AST_TX_ACK_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_word[DATA_W-5]) |-> lock_held); // R3
   AST_LEN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      pay_len_valid |-> (pay_len != '0 && pay_len <= LEN_W'(MAX_LEN))); // R6
   AST_LEN_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(pay_len_valid && err_pulse)); // R7
   AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && hdr_phase && in_data[DATA_W-1:DATA_W-4] == 4'h2) |=> !lock_held); // R9
   AST_STALL_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> !in_ready); // R11
endmodule

bind netcmd_decoder netcmd_decoder_chk #(
   .DATA_W (DATA_W),
   .LEN_W  (LEN_W),
   .MAX_LEN(MAX_LEN)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_ready     (in_ready),
   .in_data      (in_data),
   .hdr_phase    (hdr_phase),
   .ack_valid    (ack_valid),
   .ack_word     (ack_word),
   .pay_len      (pay_len),
   .pay_len_valid(pay_len_valid),
   .err_pulse    (err_pulse),
   .lock_held    (lock_held)
);

// File: tb/netcmd_decoder_test.sv
module netcmd_decoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_ready, ack_valid, pay_len_valid, lock_held, err_pulse;
   logic [31:0] ack_word, ack_dest, tx_ip, tx_ret_addr, rx_ip, rx_ret_addr;
   logic [15:0] tx_dst_port, tx_src_port, rx_dst_port, rx_src_port;
   logic [27:0] tx_timeout;
   logic [10:0] pay_len;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   always #5 clk = ~clk;

   netcmd_decoder uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .ack_valid(ack_valid), .ack_word(ack_word), .ack_dest(ack_dest),
      .tx_ip(tx_ip), .tx_dst_port(tx_dst_port), .tx_src_port(tx_src_port),
      .tx_ret_addr(tx_ret_addr), .tx_timeout(tx_timeout),
      .rx_ip(rx_ip), .rx_dst_port(rx_dst_port), .rx_src_port(rx_src_port),
      .rx_ret_addr(rx_ret_addr), .pay_len(pay_len), .pay_len_valid(pay_len_valid),
      .lock_held(lock_held), .err_pulse(err_pulse)
   );

   function automatic logic [31:0] f_ack(input bit is_tx);
      return {4'h5, is_tx, 27'b0};
   endfunction
   function automatic bit f_len_ok(input int len);
      return (len >= 1) && (len <= 1472);
   endfunction
   function automatic logic [31:0] f_hdr(input int len);
      return 32'h1000_0000 | (32'(len) << 17);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send(input logic [31:0] w, input int gap = 0);
      repeat (gap) @(negedge clk);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = w;
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = '0;
   endtask

   task automatic send_cfg(input logic [31:0] hdr, input logic [31:0] ip,
                           input logic [15:0] dp, input logic [15:0] sp,
                           input logic [31:0] ret, input int gap = 0);
      send(hdr);
      send(ip, gap);
      send({dp, sp}, gap);
      send(ret, gap);
   endtask

   task automatic chk_ack(input bit is_tx, input logic [31:0] ret, input string req);
      chk(ack_valid === 1'b1, req, 32'(ack_valid), 32'd1);
      chk(ack_word === f_ack(is_tx), req, ack_word, f_ack(is_tx));
      chk(ack_dest === ret, req, ack_dest, ret);
   endtask

   initial begin
      #1_500_000;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [31:0] ip, ret;
      logic [15:0] dp, sp;
      logic [27:0] to;
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(lock_held === 1'b0 && ack_valid === 1'b0, "R1 during reset", {30'b0, lock_held, ack_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready === 1'b1, "R1 in_ready", 32'(in_ready), 32'd1);
      chk(pay_len_valid === 1'b0 && err_pulse === 1'b0, "R1 pulses idle",
          {30'b0, pay_len_valid, err_pulse}, 32'd0);

      // R2 R4 receive configuration
      send_cfg(32'h3000_0000, 32'hC0A8_0001, 16'h1234, 16'h5678, 32'h0300_0000);
      chk_ack(1'b0, 32'h0300_0000, "R2 rx ack");
      chk(in_ready === 1'b0, "R11 stall during ack", 32'(in_ready), 32'd0);
      chk(rx_ip === 32'hC0A8_0001, "R2 rx ip", rx_ip, 32'hC0A8_0001);
      chk(rx_dst_port === 16'h1234, "R4 rx dst port", 32'(rx_dst_port), 32'h1234);
      chk(rx_src_port === 16'h5678, "R4 rx src port", 32'(rx_src_port), 32'h5678);
      chk(rx_ret_addr === 32'h0300_0000, "R2 rx ret", rx_ret_addr, 32'h0300_0000);
      @(negedge clk);
      chk(ack_valid === 1'b0 && in_ready === 1'b1, "R2 ack one cycle", 32'(ack_valid), 32'd0);

      // R11 gaps between configuration words
      send_cfg(32'h3000_0000, 32'h0A00_0002, 16'h00AA, 16'h00BB, 32'h0400_0000, 3);
      chk_ack(1'b0, 32'h0400_0000, "R11 gapped config");
      chk(rx_ip === 32'h0A00_0002, "R11 gapped ip", rx_ip, 32'h0A00_0002);

      // R3 transmit configuration with free lock
      send_cfg(32'h0000_00C8, 32'h0A00_0001, 16'h0400, 16'h0401, 32'h0100_0000);
      chk_ack(1'b1, 32'h0100_0000, "R3 tx ack");
      chk(lock_held === 1'b1, "R3 lock set", 32'(lock_held), 32'd1);
      chk(tx_timeout === 28'h00C8, "R3 timeout", 32'(tx_timeout), 32'hC8);
      chk(tx_ip === 32'h0A00_0001, "R3 tx ip", tx_ip, 32'h0A00_0001);
      chk(tx_dst_port === 16'h0400 && tx_src_port === 16'h0401, "R4 tx ports",
          {tx_dst_port, tx_src_port}, 32'h0400_0401);

      // R5 other owner refused
      send_cfg(32'h0000_0010, 32'hDEAD_BEEF, 16'h1111, 16'h2222, 32'h0200_0000);
      chk(ack_valid === 1'b0, "R5 no ack for other owner", 32'(ack_valid), 32'd0);
      chk(tx_ip === 32'h0A00_0001, "R5 tx ip unchanged", tx_ip, 32'h0A00_0001);
      chk(tx_ret_addr === 32'h0100_0000, "R5 owner unchanged", tx_ret_addr, 32'h0100_0000);
      chk(lock_held === 1'b1, "R5 lock still held", 32'(lock_held), 32'd1);
      // R5 holder reconfigures
      send_cfg(32'h0000_0300, 32'h0A00_0009, 16'h0500, 16'h0501, 32'h0100_0000);
      chk_ack(1'b1, 32'h0100_0000, "R5 regrant");
      chk(tx_ip === 32'h0A00_0009, "R5 regrant ip", tx_ip, 32'h0A00_0009);

      // R9 release
      send(32'h2000_0000);
      chk(lock_held === 1'b0, "R9 released", 32'(lock_held), 32'd0);
      chk(err_pulse === 1'b0, "R9 no error", 32'(err_pulse), 32'd0);

      // R10 timeout of 5 cycles
      send_cfg(32'h0000_0005, 32'h0A00_0003, 16'h0001, 16'h0002, 32'h0200_0000);
      chk_ack(1'b1, 32'h0200_0000, "R10 grant");
      repeat (5) @(negedge clk);
      chk(lock_held === 1'b1, "R10 held through T", 32'(lock_held), 32'd1);
      @(negedge clk);
      chk(lock_held === 1'b0, "R10 expired", 32'(lock_held), 32'd0);

      // R6 R7 length corners
      send(f_hdr(1));
      chk(pay_len_valid === 1'b1 && pay_len === 11'd1, "R6 len 1", 32'(pay_len), 32'd1);
      @(negedge clk);
      chk(pay_len_valid === 1'b0, "R6 one-cycle pulse", 32'(pay_len_valid), 32'd0);
      send(f_hdr(1472));
      chk(pay_len_valid === 1'b1 && pay_len === 11'd1472, "R6 len 1472", 32'(pay_len), 32'd1472);
      send(f_hdr(1473));
      chk(err_pulse === 1'b1 && pay_len_valid === 1'b0, "R7 len 1473", {30'b0, err_pulse, pay_len_valid}, 32'd2);
      chk(pay_len === 11'd1472, "R7 length kept", 32'(pay_len), 32'd1472);
      @(negedge clk);
      chk(err_pulse === 1'b0, "R7 one-cycle error", 32'(err_pulse), 32'd0);
      send(f_hdr(0));
      chk(err_pulse === 1'b1 && pay_len_valid === 1'b0, "R7 len 0", {30'b0, err_pulse, pay_len_valid}, 32'd2);

      // R8 unknown opcodes
      send(32'h5000_0000);
      chk(err_pulse === 1'b1, "R8 opcode 5", 32'(err_pulse), 32'd1);
      send(32'hF123_4567);
      chk(err_pulse === 1'b1, "R8 opcode F", 32'(err_pulse), 32'd1);

      // constrained random mix
      for (int i = 0; i < 400; i++) begin
         int kind;
         kind = int'($urandom % 4);
         ip  = $urandom;
         dp  = 16'($urandom);
         sp  = 16'($urandom);
         ret = $urandom;
         case (kind)
            0: begin
               send_cfg(32'h3000_0000 | ($urandom & 32'h0FFF_FFFF), ip, dp, sp, ret, int'($urandom % 3));
               chk_ack(1'b0, ret, "R2 random rx");
               chk(rx_ip === ip && rx_dst_port === dp && rx_src_port === sp, "R4 random rx fields",
                   rx_ip, ip);
            end
            1: begin
               int len;
               bit ok;
               len = int'($urandom % 2048);
               ok  = f_len_ok(len);
               send(f_hdr(len) | ($urandom & 32'h0001_FFFF));
               chk(pay_len_valid === ok, "R6 random len valid", 32'(pay_len_valid), 32'(ok));
               chk(err_pulse === !ok, "R7 random len error", 32'(err_pulse), 32'(!ok));
               if (ok) chk(pay_len === 11'(len), "R6 random len value", 32'(pay_len), 32'(len));
            end
            2: begin
               logic [3:0] opc;
               opc = 4'(4 + ($urandom % 12));
               send({opc, 28'($urandom)});
               chk(err_pulse === 1'b1, "R8 random opcode", 32'(err_pulse), 32'd1);
            end
            default: begin
               to = 28'(1000 + ($urandom % 4096));
               send_cfg({4'h0, to}, ip, dp, sp, ret);
               chk_ack(1'b1, ret, "R3 random tx");
               chk(tx_timeout === to && tx_ip === ip, "R3 random tx fields", 32'(tx_timeout), 32'(to));
               send(32'h2000_0000);
               chk(lock_held === 1'b0, "R9 random release", 32'(lock_held), 32'd0);
            end
         endcase
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule